// File: doc/BRIEF.md
# Trace Port Word Packer

This block sits between a processor trace port and the trace capture RAM. On every cycle in which a trace sample is valid, it takes that sample, which is made of a 3-bit pipeline status, a packet value and a sync flag. It places the sample in the next free slot of a 32-bit word. When the word is full, the block presents it for one cycle together with a write-valid pulse, and the RAM side stores it.

A width mode sets the packet width of the trace port to 4, 8 or 16 bits. The mode decides how wide each slot is and how many slots fit in one word. A trigger input marks the sample on which capture was triggered. The block folds this marker into the status field of the slot, so that no extra storage bit is needed for it.

Dropping enable flushes any word that is partly filled. The configuration inputs take effect only while the packer is disabled and holds nothing. A combination of port mode and width that the packer cannot capture raises an error flag, and the block then refuses all samples.

Top module: `trace_word_packer`

## Requirements
- R1: Width mode 0 (4-bit) packs three samples per word into 8-bit slots at bits [7:0], [15:8] and [23:16], first sample lowest. Each slot holds status in [2:0], packet[3:0] in [6:3] and sync in bit 7.
- R2: Width mode 1 (8-bit) packs two samples per word into 12-bit slots at bits [11:0] and [23:12]. Each slot holds status in [2:0], packet[7:0] in [10:3] and sync in bit 11.
- R3: Width mode 2 (16-bit) puts one sample in each word: status in [2:0], packet[15:0] in [18:3] and sync in bit 19.
- R4: Every word bit above the slots in use is zero, and bits [31:24] are zero in all modes.
- R5: For a sample with trigger_i high, the slot status field holds the trigger code TRIG_CODE (default 3'b111). The real pipeline status replaces the low 3 bits of the packet field, and the other packet bits are kept.
- R6: word_valid_o is high for exactly one cycle, in the cycle after the edge that accepts the sample completing a word. word_o holds that word during that cycle.
- R7: fmt_empty_o is high exactly when no partly filled word is pending. It is 0 after the first sample of a multi-slot word, and 1 again once the word is emitted.
- R8: When enable_i is low while a partial word is pending, that word is emitted with its unfilled slots zero, and fmt_empty_o is 1 in the following cycle. Samples presented while enable_i is low are ignored.
- R9: width_mode_i and port_mode_i are latched only on edges where enable_i is low and fmt_empty_o is high. Changes while enabled have no effect on packing.
- R10: port_mode_i encodes 0 as normal, 1 as demultiplexed, 2 as multiplexed and 3 as reserved. width_mode_i value 3 is reserved. cfg_err_o rises after the latch when the configuration is a reserved code, multiplexed, or demultiplexed with a width other than 8-bit. While cfg_err_o is high, no sample is accepted and no word is emitted.
- R11: After reset: word_valid_o=0, word_o=0, fmt_empty_o=1, cfg_err_o=0, and the latched configuration is 4-bit normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Capture enable; low flushes a pending partial word |
| width_mode_i | input | 2 | Packet width select: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit |
| port_mode_i | input | 2 | 0 = normal, 1 = demultiplexed, 2 = multiplexed |
| sample_valid_i | input | 1 | A trace sample is present this cycle |
| pipestat_i | input | 3 | Pipeline status of the sample |
| packet_i | input | 16 | Trace packet; low bits are used in narrow modes |
| sync_i | input | 1 | Sync flag of the sample |
| trigger_i | input | 1 | Sample is the trigger cycle |
| word_o | output | 32 | Packed word |
| word_valid_o | output | 1 | word_o is a new word this cycle |
| fmt_empty_o | output | 1 | No partial word pending |
| cfg_err_o | output | 1 | Latched configuration cannot be captured |

## Verification
A flush can fall in the same cycle as an incoming sample. This happens when enable_i drops while sample_valid_i is still high and a partial word is pending. The bench provokes exactly this case and expects a single word holding only the earlier samples, with the late sample lost and the empty flag high one cycle later.

A trigger can also coincide with the sample that completes a word. In that case the status and packet fields must be rearranged in the same cycle that the word is emitted. The scoreboard compares every emitted word in full against words that the bench builds from the slot layouts.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  typedef enum logic [1:0] {WM_4 = 2'd0, WM_8 = 2'd1, WM_16 = 2'd2, WM_RSVD = 2'd3} width_mode_e;
  typedef enum logic [1:0] {PM_NORMAL = 2'd0, PM_DEMUX = 2'd1, PM_MUX = 2'd2, PM_RSVD = 2'd3} port_mode_e;

  function automatic logic [5:0] slot_bits(width_mode_e m);
    case (m)
      WM_4:    return 6'd8;
      WM_8:    return 6'd12;
      default: return 6'd20;
    endcase
  endfunction

  function automatic logic [1:0] slot_count(width_mode_e m);
    case (m)
      WM_4:    return 2'd3;
      WM_8:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/tpk_slot_encoder.sv
module tpk_slot_encoder
  import tpk_pkg::*;
#(
  parameter int unsigned ST_W      = 3,
  parameter int unsigned PKT_W     = 16,
  parameter logic [2:0]  TRIG_CODE = 3'b111,
  localparam int unsigned SLOT_W   = ST_W + PKT_W + 1
) (
  input  width_mode_e        mode_i,
  input  logic [ST_W-1:0]    st_i,
  input  logic [PKT_W-1:0]   pkt_i,
  input  logic               sync_i,
  input  logic               trig_i,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [ST_W-1:0]  st_eff;
  logic [PKT_W-1:0] pkt_eff;

  // trigger: marker code in status field, real status moves into packet low bits
  always_comb begin
    pkt_eff = pkt_i;
    st_eff  = st_i;
    if (trig_i) begin
      pkt_eff[ST_W-1:0] = st_i;
      st_eff            = TRIG_CODE[ST_W-1:0];
    end
  end

  always_comb begin
    slot_o = '0;
    slot_o[ST_W-1:0] = st_eff;
    case (mode_i)
      WM_4: begin
        slot_o[ST_W +: 4] = pkt_eff[3:0];
        slot_o[ST_W + 4]  = sync_i;
      end
      WM_8: begin
        slot_o[ST_W +: 8] = pkt_eff[7:0];
        slot_o[ST_W + 8]  = sync_i;
      end
      default: begin
        slot_o[ST_W +: PKT_W] = pkt_eff;
        slot_o[ST_W + PKT_W]  = sync_i;
      end
    endcase
  end
endmodule

// File: rtl/tpk_cfg_ctrl.sv
module tpk_cfg_ctrl
  import tpk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        empty_i,
  input  logic [1:0]  width_i,
  input  logic [1:0]  port_i,
  output width_mode_e mode_o,
  output logic        err_o
);
  width_mode_e mode_q;
  logic        err_q;
  logic        legal;
  width_mode_e w_in;
  port_mode_e  p_in;

  assign w_in  = width_mode_e'(width_i);
  assign p_in  = port_mode_e'(port_i);
  assign legal = (w_in != WM_RSVD) &&
                 ((p_in == PM_NORMAL) || ((p_in == PM_DEMUX) && (w_in == WM_8)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WM_4;
      err_q  <= 1'b0;
    end else if (!enable_i && empty_i) begin
      mode_q <= w_in;
      err_q  <= !legal;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(mode_q) && $stable(err_q)));
endmodule

// File: rtl/tpk_assembler.sv
module tpk_assembler
  import tpk_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  width_mode_e       mode_i,
  input  logic              err_i,
  input  logic              enable_i,
  input  logic              sample_valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              empty_o
);
  logic [1:0]        count_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [5:0]        shift;
  logic [WORD_W-1:0] merged;
  logic              accept;
  logic              last;

  assign accept = enable_i && sample_valid_i && !err_i;
  assign shift  = 6'(count_q) * slot_bits(mode_i);
  assign merged = acc_q | (WORD_W'(slot_i) << shift);
  assign last   = (count_q == slot_count(mode_i) - 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        if (last) begin
          word_q  <= merged;
          valid_q <= 1'b1;
          acc_q   <= '0;
          count_q <= '0;
        end else begin
          acc_q   <= merged;
          count_q <= count_q + 2'd1;
        end
      end else if (!enable_i && count_q != 2'd0) begin
        word_q  <= acc_q;
        valid_q <= 1'b1;
        acc_q   <= '0;
        count_q <= '0;
      end
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;
  assign empty_o      = (count_q == 2'd0);

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_o[WORD_W-1:24] == '0));
  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !empty_o) |=> (empty_o && word_valid_o));
  p_err_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && enable_i) |=> !word_valid_o);
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q < slot_count(mode_i));
endmodule

// File: rtl/trace_word_packer.sv
module trace_word_packer
  import tpk_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ST_W      = 3,
  parameter int unsigned PKT_W     = 16,
  parameter logic [2:0]  TRIG_CODE = 3'b111,
  localparam int unsigned SLOT_W   = ST_W + PKT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [1:0]        width_mode_i,
  input  logic [1:0]        port_mode_i,
  input  logic              sample_valid_i,
  input  logic [ST_W-1:0]   pipestat_i,
  input  logic [PKT_W-1:0]  packet_i,
  input  logic              sync_i,
  input  logic              trigger_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              fmt_empty_o,
  output logic              cfg_err_o
);
  width_mode_e       mode;
  logic              err;
  logic              empty;
  logic [SLOT_W-1:0] slot;

  tpk_cfg_ctrl u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .empty_i  (empty),
    .width_i  (width_mode_i),
    .port_i   (port_mode_i),
    .mode_o   (mode),
    .err_o    (err)
  );

  tpk_slot_encoder #(
    .ST_W      (ST_W),
    .PKT_W     (PKT_W),
    .TRIG_CODE (TRIG_CODE)
  ) u_enc (
    .mode_i (mode),
    .st_i   (pipestat_i),
    .pkt_i  (packet_i),
    .sync_i (sync_i),
    .trig_i (trigger_i),
    .slot_o (slot)
  );

  tpk_assembler #(
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W)
  ) u_asm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode),
    .err_i          (err),
    .enable_i       (enable_i),
    .sample_valid_i (sample_valid_i),
    .slot_i         (slot),
    .word_o         (word_o),
    .word_valid_o   (word_valid_o),
    .empty_o        (empty)
  );

  assign fmt_empty_o = empty;
  assign cfg_err_o   = err;
endmodule

// File: tb/sim_trace_word_packer.sv
module sim_trace_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [1:0]  width_mode_i = 2'd0;
  logic [1:0]  port_mode_i = 2'd0;
  logic        sample_valid_i = 1'b0;
  logic [2:0]  pipestat_i = '0;
  logic [15:0] packet_i = '0;
  logic        sync_i = 1'b0;
  logic        trigger_i = 1'b0;
  logic [31:0] word_o;
  logic        word_valid_o;
  logic        fmt_empty_o;
  logic        cfg_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  int          m_mode = 0;
  bit          m_err = 1'b0;
  bit          m_en = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_acc = '0;
  string       m_tag = "R1";

  always #10 clk = ~clk;

  trace_word_packer u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i), .width_mode_i(width_mode_i),
    .port_mode_i(port_mode_i), .sample_valid_i(sample_valid_i), .pipestat_i(pipestat_i),
    .packet_i(packet_i), .sync_i(sync_i), .trigger_i(trigger_i), .word_o(word_o),
    .word_valid_o(word_valid_o), .fmt_empty_o(fmt_empty_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] b_slot(int md, int st, int pkt, bit sy, bit tr);
    int s = st;
    int p = pkt;
    if (tr) begin
      p = (p & ~7) | st;
      s = 7;
    end
    case (md)
      0:       return 32'((int'(sy) << 7)  | ((p & 'hF)    << 3) | s);
      1:       return 32'((int'(sy) << 11) | ((p & 'hFF)   << 3) | s);
      default: return 32'((int'(sy) << 19) | ((p & 'hFFFF) << 3) | s);
    endcase
  endfunction

  function automatic int b_lim(int md);
    return (md == 0) ? 3 : (md == 1) ? 2 : 1;
  endfunction

  function automatic int b_sw(int md);
    return (md == 0) ? 8 : 12;
  endfunction

  // monitor: compare each emitted word against the scoreboard
  always @(posedge clk) begin
    #5;
    if (rst_n && word_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R6 unexpected word actual=%h expected=none", word_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (word_o !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, word_o, e);
        end
        checks++;
        if (word_o[31:24] !== 8'h00) begin
          failures++;
          $display("FAIL R4 actual=%h expected=00", word_o[31:24]);
        end
      end
    end
  end

  task automatic send(int st, int pkt, bit sy, bit tr);
    @(negedge clk);
    sample_valid_i = 1'b1;
    pipestat_i = 3'(st);
    packet_i = 16'(pkt);
    sync_i = sy;
    trigger_i = tr;
    if (m_en && !m_err) begin
      m_acc = m_acc | (b_slot(m_mode, st, pkt, sy, tr) << (m_cnt * b_sw(m_mode)));
      m_cnt++;
      if (m_cnt == b_lim(m_mode)) begin
        exp_q.push_back(m_acc);
        tag_q.push_back(m_tag);
        m_acc = '0;
        m_cnt = 0;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_valid_i = 1'b0;
      trigger_i = 1'b0;
    end
  endtask

  task automatic start();
    @(negedge clk);
    sample_valid_i = 1'b0;
    enable_i = 1'b1;
    m_en = 1'b1;
  endtask

  // disable; keep_valid leaves a sample on the bus in the same cycle
  task automatic stop(bit keep_valid);
    @(negedge clk);
    enable_i = 1'b0;
    m_en = 1'b0;
    sample_valid_i = keep_valid;
    if (m_cnt != 0) begin
      exp_q.push_back(m_acc);
      tag_q.push_back("R8");
      m_acc = '0;
      m_cnt = 0;
    end
  endtask

  task automatic set_cfg(int w, int p);
    @(negedge clk);
    width_mode_i = 2'(w);
    port_mode_i = 2'(p);
    m_mode = w;
    m_err = !((w != 3) && (p == 0 || (p == 1 && w == 1)));
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 valid", 32'(word_valid_o), 0);
    check("R11 word", word_o, 0);
    check("R11 empty", 32'(fmt_empty_o), 1);
    check("R11 err", 32'(cfg_err_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 4-bit default, back-to-back
    m_tag = "R1";
    start();
    send(1, 'h5, 0, 0);
    idle(1);
    #1 check("R7 empty after 1 sample", 32'(fmt_empty_o), 0);
    send(2, 'hA, 1, 0);
    send(4, 'hF, 0, 0);
    idle(1);
    #1 check("R7 empty after word", 32'(fmt_empty_o), 1);
    send(6, 'h3, 1, 0);
    send(0, 'hC, 0, 0);
    send(7, 'h9, 1, 0);
    idle(2);

    // R5 trigger on the word-completing sample
    m_tag = "R5";
    send(3, 'h2, 0, 0);
    send(1, 'h6, 1, 0);
    send(5, 'hA, 0, 1);
    idle(2);

    // R8 flush with a sample on the bus in the same cycle
    send(2, 'h7, 1, 0);
    send(3, 'h1, 0, 0);
    stop(1'b1);
    idle(1);
    #1 check("R8 empty after flush", 32'(fmt_empty_o), 1);
    idle(2);
    #1 check("R8 ignored while disabled", 32'(fmt_empty_o), 1);

    // R2 8-bit; R9 width change while enabled is ignored
    set_cfg(1, 0);
    m_tag = "R2";
    start();
    send(1, 'hA5, 1, 0);
    send(6, 'h3C, 0, 1);
    idle(1);
    m_tag = "R9";
    send(4, 'h81, 0, 0);
    width_mode_i = 2'd0;
    send(2, 'hFE, 1, 0);
    idle(2);
    stop(1'b0);
    idle(2);

    // R3 16-bit back-to-back
    set_cfg(2, 0);
    m_tag = "R3";
    start();
    send(3, 'hBEEF, 1, 0);
    send(0, 'h1234, 0, 0);
    send(5, 'hFFF8, 1, 1);
    idle(2);
    stop(1'b0);

    // R10 legal demux with 8-bit
    set_cfg(1, 1);
    #1 check("R10 demux 8-bit legal", 32'(cfg_err_o), 0);
    m_tag = "R10";
    start();
    send(7, 'h55, 0, 0);
    send(1, 'hAA, 1, 0);
    idle(2);
    stop(1'b0);

    // R10 illegal combinations
    set_cfg(0, 1);
    #1 check("R10 demux 4-bit err", 32'(cfg_err_o), 1);
    start();
    send(1, 1, 0, 0);
    send(2, 2, 0, 0);
    send(3, 3, 0, 0);
    idle(2);
    #1 check("R10 nothing accepted", 32'(fmt_empty_o), 1);
    stop(1'b0);
    set_cfg(1, 2);
    #1 check("R10 mux err", 32'(cfg_err_o), 1);
    set_cfg(3, 0);
    #1 check("R10 reserved width err", 32'(cfg_err_o), 1);
    set_cfg(0, 0);
    #1 check("R10 legal again", 32'(cfg_err_o), 0);
    idle(3);

    check("R6 all words seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule